// File: doc/BRIEF.md
# IDE Function Configuration Space

This block holds the byte-addressed configuration space of the IDE function in a multi-function bridge. A host-side access engine presents a function number, a byte offset and a read or write strobe. The block answers only for its own function number. Each writable byte takes new data only through its own mask. Every other offset is a constant that is fixed at reset.

The block also produces three outputs from that space. Two flags switch address decode for the primary and secondary drive channels on or off. A 16-bit I/O base address tells the bus-master register window where to sit. Reads return one byte through a registered data path. Function numbers above the highest implemented function read as all ones. Function 0 belongs to a neighbouring block, so this block returns zero for it.

Top module: `ide_cfg_space`

## Requirements
- R1: After reset, function 1 reads 0x86, 0x80, 0x30, 0x12 at offsets 0x00 to 0x03, reads 0x80, 0x01, 0x01 at offsets 0x09 to 0x0B, 0x02 at 0x07 and 0x01 at 0x20, and 0x00 at every other offset. Both decode enables, the base address and the read data are zero.
- R2: Accesses with a function number above 1 change no state, and a read of such a function returns 0xFF.
- R3: Accesses to function 0 change no state in this block, and a read of function 0 returns 0x00.
- R4: A write to offset 0x04 changes only bit 0. A write to offset 0x07 changes only bits 5:3, and its other bits keep their values (bit 1 stays 1).
- R5: Offsets 0x0D, 0x21, 0x40, 0x41, 0x42 and 0x43 store the whole written byte.
- R6: A write to offset 0x20 stores bits 7:4 of the written byte, and bits 3:0 always read 0001.
- R7: bm_base equals {byte 0x21, byte 0x20 bits 7:4, 4'h0}. It takes its new value at the clock edge that accepts a write to offsets 0x20 to 0x23, and it does not change otherwise.
- R8: pri_dec_en follows bit 7 of offset 0x41, and sec_dec_en follows bit 7 of offset 0x43. Each changes only at the edge of a write that flips that bit.
- R9: Every other offset, including 0x22 and 0x23, ignores writes and keeps its reset value.
- R10: rdata shows the addressed byte from the clock edge that samples rd_en, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func | input | 3 | Function number of the access |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pri_dec_en | output | 1 | Primary channel decode enable |
| sec_dec_en | output | 1 | Secondary channel decode enable |
| bm_base | output | 16 | Bus-master I/O base address |

## Verification
All results are due at the first rising edge after the strobe: a stored byte, bm_base and the decode enables all change at the edge that accepts the write, and rdata changes at the edge that samples rd_en. The bench drives strobes on the falling edge, holds them for one full cycle, removes them on the next falling edge and samples there, half a period after the result is due. It keeps its own model of all 256 offsets for function 1. It checks every offset after reset and after two complementary write sweeps, and after each sweep write it also checks bm_base and both enables. Separate checks confirm that rdata holds across idle cycles and writes.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

   localparam int NUM_WR      = 9;
   localparam int IDX_BASE_LO = 3;
   localparam int IDX_BASE_HI = 4;

   localparam logic [7:0] OFF_BASE_LO = 8'h20;
   localparam logic [7:0] OFF_BASE_HI = 8'h21;
   localparam logic [7:0] OFF_PRI     = 8'h41;
   localparam logic [7:0] OFF_SEC     = 8'h43;
   localparam logic [5:0] BASE_GROUP  = 6'h08;

   // Offset of each writable byte
   function automatic logic [7:0] wr_off(input int i);
      case (i)
         0:       return 8'h04;
         1:       return 8'h07;
         2:       return 8'h0D;
         3:       return OFF_BASE_LO;
         4:       return OFF_BASE_HI;
         5:       return 8'h40;
         6:       return OFF_PRI;
         7:       return 8'h42;
         default: return OFF_SEC;
      endcase
   endfunction

   // Bits a write may change
   function automatic logic [7:0] wr_mask(input int i);
      case (i)
         0:       return 8'h01;
         1:       return 8'h38;
         3:       return 8'hF0;
         default: return 8'hFF;
      endcase
   endfunction

   // Reset value; bits outside the mask keep it forever
   function automatic logic [7:0] wr_rst(input int i);
      case (i)
         1:       return 8'h02;
         3:       return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/ide_cfg_store.sv
module ide_cfg_store
   import ide_cfg_pkg::*;
#(
   parameter int NUM = NUM_WR
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_hit,
   input  logic [7:0]              addr,
   input  logic [7:0]              wdata,
   output logic [NUM-1:0][7:0]     q,
   output logic [NUM-1:0]          sel
);

   generate
      if (NUM != NUM_WR) begin : g_bad_num
         $error("ide_cfg_store: NUM must match the writable table");
      end
      for (genvar g = 0; g < NUM; g++) begin : g_byte
         localparam logic [7:0] OFF  = wr_off(g);
         localparam logic [7:0] MASK = wr_mask(g);
         localparam logic [7:0] RST  = wr_rst(g);

         assign sel[g] = (addr == OFF);

         always_ff @(posedge clk) begin
            if (!rst_n)
               q[g] <= RST;
            else if (wr_hit && sel[g])
               q[g] <= (q[g] & ~MASK) | (wdata & MASK);
         end

         // R4 / R6: bits outside the mask survive every write
         a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && addr == OFF) |=> ((q[g] & ~MASK) == ($past(q[g]) & ~MASK)));

         // R9: the byte moves only when written
         a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_hit && addr == OFF) |=> $stable(q[g]));
      end
   endgenerate

endmodule

// File: rtl/ide_cfg_decode.sv
module ide_cfg_decode
   import ide_cfg_pkg::*;
#(
   parameter int NUM = NUM_WR
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_hit,
   input  logic [7:0]          addr,
   input  logic [7:0]          wdata,
   input  logic [NUM-1:0][7:0] q,
   output logic                pri_dec_en,
   output logic                sec_dec_en,
   output logic [15:0]         bm_base
);

   logic       base_wr;
   logic [3:0] lo_next;
   logic [7:0] hi_next;
   logic       pri_flip, sec_flip;

   assign base_wr  = wr_hit && (addr[7:2] == BASE_GROUP);
   assign lo_next  = (wr_hit && addr == OFF_BASE_LO) ? wdata[7:4] : q[IDX_BASE_LO][7:4];
   assign hi_next  = (wr_hit && addr == OFF_BASE_HI) ? wdata : q[IDX_BASE_HI];
   assign pri_flip = wr_hit && (addr == OFF_PRI) && (wdata[7] != pri_dec_en);
   assign sec_flip = wr_hit && (addr == OFF_SEC) && (wdata[7] != sec_dec_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pri_dec_en <= 1'b0;
         sec_dec_en <= 1'b0;
         bm_base    <= 16'h0000;
      end else begin
         if (pri_flip) pri_dec_en <= ~pri_dec_en;
         if (sec_flip) sec_dec_en <= ~sec_dec_en;
         if (base_wr)  bm_base    <= {hi_next, lo_next, 4'h0};
      end
   end

   // R8: enables move only on a write to their own byte
   a_r8_pri_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && addr == OFF_PRI) |=> $stable(pri_dec_en));
   a_r8_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && addr == OFF_SEC) |=> $stable(sec_dec_en));
   // R8: enable matches the stored bit after the write
   a_r8_pri_track: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && addr == OFF_PRI) |=> (pri_dec_en == $past(wdata[7])));
   // R7: base address moves only on writes to its dword
   a_r7_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !base_wr |=> $stable(bm_base));

endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux
   import ide_cfg_pkg::*;
#(
   parameter int          NUM        = NUM_WR,
   parameter logic [15:0] VENDOR_ID  = 16'h8086,
   parameter logic [15:0] DEVICE_ID  = 16'h1230,
   parameter logic [23:0] CLASS_CODE = 24'h010180
) (
   input  logic [7:0]          addr,
   input  logic [NUM-1:0][7:0] q,
   input  logic [NUM-1:0]      sel,
   output logic [7:0]          rbyte
);

   function automatic logic [7:0] const_byte(input logic [7:0] a);
      case (a)
         8'h00:   return VENDOR_ID[7:0];
         8'h01:   return VENDOR_ID[15:8];
         8'h02:   return DEVICE_ID[7:0];
         8'h03:   return DEVICE_ID[15:8];
         8'h09:   return CLASS_CODE[7:0];
         8'h0A:   return CLASS_CODE[15:8];
         8'h0B:   return CLASS_CODE[23:16];
         default: return 8'h00;
      endcase
   endfunction

   always_comb begin
      rbyte = const_byte(addr);
      for (int i = 0; i < NUM; i++)
         if (sel[i]) rbyte = q[i];
   end

endmodule

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
   import ide_cfg_pkg::*;
#(
   parameter int          FUNC_W     = 3,
   parameter int          IDE_FUNC   = 1,
   parameter int          MAX_FUNC   = 1,
   parameter logic [15:0] VENDOR_ID  = 16'h8086,
   parameter logic [15:0] DEVICE_ID  = 16'h1230,
   parameter logic [23:0] CLASS_CODE = 24'h010180
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUNC_W-1:0] func,
   input  logic [7:0]        addr,
   input  logic              wr_en,
   input  logic [7:0]        wdata,
   input  logic              rd_en,
   output logic [7:0]        rdata,
   output logic              pri_dec_en,
   output logic              sec_dec_en,
   output logic [15:0]       bm_base
);

   localparam logic [FUNC_W-1:0] OWN_F = FUNC_W'(IDE_FUNC);
   localparam logic [FUNC_W-1:0] TOP_F = FUNC_W'(MAX_FUNC);

   generate
      if (IDE_FUNC > MAX_FUNC) begin : g_bad_func
         $error("ide_cfg_space: IDE_FUNC beyond MAX_FUNC");
      end
      if (MAX_FUNC >= (1 << FUNC_W)) begin : g_bad_width
         $error("ide_cfg_space: FUNC_W too narrow for MAX_FUNC");
      end
   endgenerate

   logic                   own, wr_hit;
   logic [NUM_WR-1:0][7:0] q;
   logic [NUM_WR-1:0]      sel;
   logic [7:0]             rbyte;

   assign own    = (func == OWN_F);
   assign wr_hit = wr_en && own;

   ide_cfg_store #(.NUM(NUM_WR)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .addr(addr),
      .wdata(wdata), .q(q), .sel(sel)
   );

   ide_cfg_decode #(.NUM(NUM_WR)) u_decode (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .addr(addr), .wdata(wdata),
      .q(q), .pri_dec_en(pri_dec_en), .sec_dec_en(sec_dec_en), .bm_base(bm_base)
   );

   ide_cfg_rdmux #(
      .NUM(NUM_WR), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE)
   ) u_rdmux (
      .addr(addr), .q(q), .sel(sel), .rbyte(rbyte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= 8'h00;
      else if (rd_en) begin
         if (func > TOP_F)
            rdata <= 8'hFF;
         else if (!own)
            rdata <= 8'h00;
         else
            rdata <= rbyte;
      end
   end

   // R2: unimplemented functions read all ones
   a_r2_high_func_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && func > TOP_F) |=> (rdata == 8'hFF));
   // R3: the neighbouring function reads zero here
   a_r3_other_func_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && func <= TOP_F && !own) |=> (rdata == 8'h00));
   // R10: read data holds between reads
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

// File: tb/ide_cfg_space_bench.sv
`timescale 1ns/1ps
module ide_cfg_space_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  func = '0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rdata;
   logic        pri_dec_en, sec_dec_en;
   logic [15:0] bm_base;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] mdl [256];

   always #2.5 clk = ~clk;

   ide_cfg_space u_ide_cfg_space (
      .clk(clk), .rst_n(rst_n), .func(func), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .pri_dec_en(pri_dec_en),
      .sec_dec_en(sec_dec_en), .bm_base(bm_base)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [7:0] a);
      if (a == 8'h04 || a == 8'h07) return "R4";
      if (a == 8'h20) return "R6";
      if (a == 8'h0D || a == 8'h21 || (a >= 8'h40 && a <= 8'h43)) return "R5";
      return "R9";
   endfunction

   // Model of one write to function 1, taken from the requirements
   task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
      case (a)
         8'h04: mdl[a] = (mdl[a] & 8'hFE) | (d & 8'h01);
         8'h07: mdl[a] = (mdl[a] & 8'hC7) | (d & 8'h38);
         8'h20: mdl[a] = (d & 8'hF0) | 8'h01;
         8'h0D, 8'h21, 8'h40, 8'h41, 8'h42, 8'h43: mdl[a] = d;
         default: ;
      endcase
   endtask

   function automatic logic [15:0] exp_base();
      return {mdl[8'h21], mdl[8'h20][7:4], 4'h0};
   endfunction

   task automatic do_wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; func = f; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (f == 3'd1) mdl_write(a, d);
   endtask

   task automatic do_rd(input logic [2:0] f, input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1; func = f; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic sweep_read(input bit after_reset);
      logic [7:0] v;
      for (int a = 0; a < 256; a++) begin
         do_rd(3'd1, 8'(a), v);
         chk(after_reset ? "R1" : tag_of(8'(a)), 32'(v), 32'(mdl[a]));
      end
   endtask

   task automatic sweep_write(input logic [7:0] key);
      for (int a = 0; a < 256; a++) begin
         do_wr(3'd1, 8'(a), 8'(a) ^ key);
         chk("R7", 32'(bm_base), 32'(exp_base()));
         chk("R8", 32'(pri_dec_en), 32'(mdl[8'h41][7]));
         chk("R8", 32'(sec_dec_en), 32'(mdl[8'h43][7]));
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] v;
      logic [15:0] base0;
      for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
      mdl[8'h00] = 8'h86; mdl[8'h01] = 8'h80; mdl[8'h02] = 8'h30; mdl[8'h03] = 8'h12;
      mdl[8'h07] = 8'h02; mdl[8'h09] = 8'h80; mdl[8'h0A] = 8'h01; mdl[8'h0B] = 8'h01;
      mdl[8'h20] = 8'h01;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: outputs after reset
      chk("R1", 32'(rdata), 0);
      chk("R1", 32'(pri_dec_en), 0);
      chk("R1", 32'(sec_dec_en), 0);
      chk("R1", 32'(bm_base), 0);
      sweep_read(1'b1);

      // R2 / R3: other function numbers
      for (int f = 0; f < 8; f++) begin
         if (f == 1) continue;
         do_rd(3'(f), 8'h00, v);
         chk(f == 0 ? "R3" : "R2", 32'(v), f == 0 ? 32'h00 : 32'hFF);
         do_rd(3'(f), 8'h41, v);
         chk(f == 0 ? "R3" : "R2", 32'(v), f == 0 ? 32'h00 : 32'hFF);
      end

      // R4 R5 R6 R7 R8 R9: two complementary sweeps
      sweep_write(8'hA5);
      sweep_read(1'b0);
      sweep_write(8'h5A);
      sweep_read(1'b0);

      // R8: explicit toggle sequence
      do_wr(3'd1, 8'h41, 8'h80); chk("R8", 32'(pri_dec_en), 1);
      do_wr(3'd1, 8'h41, 8'h81); chk("R8", 32'(pri_dec_en), 1);
      do_wr(3'd1, 8'h41, 8'h7F); chk("R8", 32'(pri_dec_en), 0);
      do_wr(3'd1, 8'h43, 8'hC0); chk("R8", 32'(sec_dec_en), 1);
      chk("R8", 32'(pri_dec_en), 0);
      do_wr(3'd1, 8'h43, 8'h00); chk("R8", 32'(sec_dec_en), 0);

      // R7: base composition and writes to 0x22/0x23
      do_wr(3'd1, 8'h20, 8'hFF); do_wr(3'd1, 8'h21, 8'hC3);
      chk("R7", 32'(bm_base), 32'hC3F0);
      do_wr(3'd1, 8'h22, 8'h55); do_wr(3'd1, 8'h23, 8'h66);
      chk("R7", 32'(bm_base), 32'hC3F0);
      do_rd(3'd1, 8'h22, v); chk("R9", 32'(v), 0);
      do_rd(3'd1, 8'h20, v); chk("R6", 32'(v), 32'hF1);

      // R2 / R3: writes to other functions leave state alone
      base0 = bm_base;
      for (int f = 0; f < 8; f++) begin
         if (f == 1) continue;
         do_wr(3'(f), 8'h41, 8'hFF);
         do_wr(3'(f), 8'h21, 8'h77);
         do_wr(3'(f), 8'h04, 8'hFF);
         chk(f == 0 ? "R3" : "R2", 32'(pri_dec_en), 0);
         chk(f == 0 ? "R3" : "R2", 32'(bm_base), 32'(base0));
      end
      do_rd(3'd1, 8'h41, v); chk("R2", 32'(v), 32'(mdl[8'h41]));
      do_rd(3'd1, 8'h04, v); chk("R3", 32'(v), 32'(mdl[8'h04]));

      // R10: read data holds across idle cycles and writes
      do_rd(3'd1, 8'h00, v); chk("R10", 32'(v), 32'h86);
      repeat (3) @(negedge clk);
      chk("R10", 32'(rdata), 32'h86);
      do_wr(3'd1, 8'h0D, 8'h3C);
      chk("R10", 32'(rdata), 32'h86);
      do_rd(3'd1, 8'h0D, v); chk("R10", 32'(v), 32'h3C);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule